// File: doc/BRIEF.md
# External interrupt request controller

This block collects six maskable external interrupt pins and one non-maskable pin. It decides which pending source the processor should service next. Each maskable pin is brought into the clock domain by a two-stage synchronizer. The pin is then inverted or not according to its polarity setting, and it is sensed either on an active-going edge or on the active level. A per-source request bit records the event. The non-maskable pin goes through a programmable minimum-width filter, and a falling filtered edge latches a pending flag that no setting can block.

The controller presents one source to the processor: a request line, a source number and a priority level. The processor acknowledges it with one of two strobes, one for maskable and one for high-speed service. The information word that goes with the presented source appears on a dedicated output. Software can also read the same word through the register port at two offsets. A hardware acknowledge clears the request bit of the presented source. A software read of the same word leaves every request bit as it was. An input from the processor holds off all presentation until the first instruction after reset has completed.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every request bit reads 0, every control register reads 0 (level 0, edge sense, active low), the NMI minimum width reads 2 and `irq_req` is 0.
- R2: In edge mode, a transition of a pin to its active level sets that source's request bit at the third rising clock edge, counting the edge that first samples the new pin level, because of the two synchronizer stages.
- R3: Control bit 4 set to 1 makes a pin active high, and 0 makes it active low. In edge mode, a polarity write that makes the present pin level active raises that source's request one cycle after the write.
- R4: Control bit 3 set to 1 selects level sense. The request bit then tracks the active level. An acknowledge clears it for one cycle, and it comes back on the following cycle if the level is still active.
- R5: Among requests with a non-zero 3-bit level, the highest level is presented. On equal levels the lower source number wins. A source at level 0 can hold a request but is never presented.
- R6: A maskable source is presented only when its level is strictly above `cpu_ipl`. Nothing at all is presented while `accept_en` is 0.
- R7: A cycle with `ack_mask` or `ack_fast` high while `irq_req` is 1 clears the request of the presented source. Software reads at offsets 0 and 2 return the presented information word and clear nothing.
- R8: A register write with control bit 5 at 0 clears that source's request bit. A write with bit 5 at 1 leaves the request bit unchanged.
- R9: The NMI pin (active low) is accepted only after its synchronized value has held a new level for W consecutive clocks. W comes from offset 10, and 0 is treated as 1. A shorter pulse is ignored. An accepted falling level latches NMI pending.
- R10: A pending NMI is presented as source number 6 at level 7 ahead of every maskable source, whatever `cpu_ipl` and the maskable levels are. Only `accept_en` gates it, and an acknowledge clears it.
- R11: In edge mode, if a new edge and a clear (acknowledge or software write of 0) hit the same source in the same cycle, the request ends up set.
- R12: Register map: offsets 0 and 2 read the information word. Offsets 4+i (i = 0..5) hold control for source i, with level in bits 2:0, sense in bit 3, polarity in bit 4 and request in bit 5. Offset 10 holds the NMI width in bits 7:0. Other offsets read 0. The information word has the source number in bits 2:0 and the level in bits 10:8, and it is 0 when nothing is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| accept_en | input | 1 | High once the first instruction after reset has completed |
| irq_pin | input | 6 | Maskable interrupt pins |
| nmi_pin | input | 1 | Non-maskable interrupt pin, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on `reg_addr`) |
| cpu_ipl | input | 3 | Processor interrupt priority level |
| ack_mask | input | 1 | Maskable acknowledge strobe |
| ack_fast | input | 1 | High-speed acknowledge strobe |
| irq_req | output | 1 | A source is presented |
| irq_num | output | 3 | Presented source number (6 is NMI) |
| irq_level | output | 3 | Presented request level |
| ack_info | output | 16 | Information word of the presented source |

## Verification
The assertions assume that the acknowledge strobes and register writes are single-cycle pulses sampled on the rising edge. They also assume that `accept_en` and `cpu_ipl` change only between edges. The bench drives every input just after the falling edge, so each value is stable across the next rising edge. Pin transitions may land in any cycle, including one that carries a clear. That lets the same-cycle set-versus-clear case and the polarity-induced request come up both in the directed phases and in the random phase. NMI widths are kept small in the random phase so that the filter accepts pulses within the run.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NSRC      = 6,
  parameter int LVL_W     = 3,
  parameter int WID_W     = 8,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int NMI_W_RST = 2,
  localparam int NUM_W    = $clog2(NSRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_en,
  input  logic [NSRC-1:0]   irq_pin,
  input  logic              nmi_pin,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LVL_W-1:0]  cpu_ipl,
  input  logic              ack_mask,
  input  logic              ack_fast,
  output logic              irq_req,
  output logic [NUM_W-1:0]  irq_num,
  output logic [LVL_W-1:0]  irq_level,
  output logic [DATA_W-1:0] ack_info
);
  localparam int SENSE_B   = LVL_W;
  localparam int POL_B     = LVL_W + 1;
  localparam int REQ_B     = LVL_W + 2;
  localparam int INFO_M    = 0;
  localparam int INFO_F    = 2;
  localparam int CTRL_BASE = 4;
  localparam int NMI_ADDR  = CTRL_BASE + NSRC;
  localparam int LVL_POS   = 8;

  logic [NSRC-1:0]  s1_q, s2_q, prev_q, req_q, sense_lvl, pol_hi;
  logic [LVL_W-1:0] prio_q [NSRC];
  logic [NSRC-1:0]  act, edge_evt, wr_ctl, clr, req_d;
  logic [LVL_W-1:0] best_lvl;
  logic [NUM_W-1:0] best_idx;
  logic             mask_ok, ack_any;

  logic             n1_q, n2_q, nflt_q, nmi_pend;
  logic [WID_W-1:0] ncnt_q, nwid_q;
  logic [WID_W:0]   eff_w, ncnt_inc;
  logic             n_differ, n_settle, nmi_fall, nmi_ack, wr_nmi;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[DATA_W-1:WID_W];

  assign act      = ~(s2_q ^ pol_hi);
  assign edge_evt = act & ~prev_q;
  assign ack_any  = (ack_mask | ack_fast) & irq_req;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign wr_ctl[i] = reg_we && (reg_addr == ADDR_W'(CTRL_BASE + i));
    assign clr[i]    = (ack_any && !nmi_pend && best_idx == NUM_W'(i))
                     || (wr_ctl[i] && !reg_wdata[REQ_B]);
    assign req_d[i]  = sense_lvl[i] ? (act[i] && !clr[i])
                                    : (edge_evt[i] || (req_q[i] && !clr[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q      <= '0;
      s2_q      <= '0;
      prev_q    <= '1;
      req_q     <= '0;
      sense_lvl <= '0;
      pol_hi    <= '0;
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
    end else begin
      s1_q   <= irq_pin;
      s2_q   <= s1_q;
      prev_q <= act;
      req_q  <= req_d;
      for (int i = 0; i < NSRC; i++) begin
        if (wr_ctl[i]) begin
          prio_q[i]    <= reg_wdata[LVL_W-1:0];
          sense_lvl[i] <= reg_wdata[SENSE_B];
          pol_hi[i]    <= reg_wdata[POL_B];
        end
      end
    end
  end

  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req_q[i] && prio_q[i] > best_lvl) begin
        best_lvl = prio_q[i];
        best_idx = NUM_W'(i);
      end
    end
  end

  assign eff_w    = (nwid_q == '0) ? (WID_W+1)'(1) : {1'b0, nwid_q};
  assign ncnt_inc = {1'b0, ncnt_q} + (WID_W+1)'(1);
  assign n_differ = n2_q != nflt_q;
  assign n_settle = n_differ && (ncnt_inc >= eff_w);
  assign nmi_fall = n_settle && !n2_q;
  assign nmi_ack  = ack_any && nmi_pend;
  assign wr_nmi   = reg_we && (reg_addr == ADDR_W'(NMI_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n1_q     <= 1'b1;
      n2_q     <= 1'b1;
      nflt_q   <= 1'b1;
      ncnt_q   <= '0;
      nwid_q   <= WID_W'(NMI_W_RST);
      nmi_pend <= 1'b0;
    end else begin
      n1_q <= nmi_pin;
      n2_q <= n1_q;
      if (n_settle) begin
        nflt_q <= n2_q;
        ncnt_q <= '0;
      end else if (n_differ) begin
        ncnt_q <= ncnt_inc[WID_W-1:0];
      end else begin
        ncnt_q <= '0;
      end
      if (nmi_fall)     nmi_pend <= 1'b1;
      else if (nmi_ack) nmi_pend <= 1'b0;
      if (wr_nmi) nwid_q <= reg_wdata[WID_W-1:0];
    end
  end

  assign mask_ok   = (best_lvl != '0) && (best_lvl > cpu_ipl);
  assign irq_req   = accept_en && (nmi_pend || mask_ok);
  assign irq_num   = !irq_req ? '0 : (nmi_pend ? NUM_W'(NSRC) : best_idx);
  assign irq_level = !irq_req ? '0 : (nmi_pend ? '1 : best_lvl);

  always_comb begin
    ack_info = '0;
    ack_info[NUM_W-1:0] = irq_num;
    ack_info[LVL_POS +: LVL_W] = irq_level;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(INFO_M) || reg_addr == ADDR_W'(INFO_F))
      reg_rdata = ack_info;
    if (reg_addr == ADDR_W'(NMI_ADDR))
      reg_rdata[WID_W-1:0] = nwid_q;
    for (int i = 0; i < NSRC; i++) begin
      if (reg_addr == ADDR_W'(CTRL_BASE + i)) begin
        reg_rdata[LVL_W-1:0] = prio_q[i];
        reg_rdata[SENSE_B]   = sense_lvl[i];
        reg_rdata[POL_B]     = pol_hi[i];
        reg_rdata[REQ_B]     = req_q[i];
      end
    end
  end
endmodule

// File: rtl/ext_irq_ctrl_sva.sv
module ext_irq_ctrl_sva #(
  parameter int NSRC  = 6,
  parameter int LVL_W = 3,
  parameter int NUM_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept_en,
  input logic [LVL_W-1:0] cpu_ipl,
  input logic             ack_mask,
  input logic             ack_fast,
  input logic             reg_we,
  input logic             irq_req,
  input logic [NUM_W-1:0] irq_num,
  input logic [LVL_W-1:0] irq_level,
  input logic [NSRC-1:0]  req_q,
  input logic [NSRC-1:0]  sense_lvl,
  input logic [NSRC-1:0]  edge_evt,
  input logic             nmi_pend
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!irq_req && req_q == '0));

  a_r6_above_ipl: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_num != NUM_W'(NSRC)) |-> (irq_level > cpu_ipl));

  a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> accept_en);

  a_r5_nonzero_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level != '0));

  a_r10_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_en && nmi_pend) |-> (irq_req && irq_num == NUM_W'(NSRC) && irq_level == '1));

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_mask || ack_fast) && irq_req && irq_num < NUM_W'(NSRC) && !edge_evt[irq_num])
      |=> !req_q[$past(irq_num)]);

  a_r7_no_silent_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ack_mask || ack_fast) && !reg_we)
      |=> (($past(req_q) & ~$past(sense_lvl) & ~req_q) == '0));
endmodule

bind ext_irq_ctrl ext_irq_ctrl_sva #(.NSRC(NSRC), .LVL_W(LVL_W), .NUM_W(NUM_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .accept_en(accept_en), .cpu_ipl(cpu_ipl),
  .ack_mask(ack_mask), .ack_fast(ack_fast), .reg_we(reg_we),
  .irq_req(irq_req), .irq_num(irq_num), .irq_level(irq_level),
  .req_q(req_q), .sense_lvl(sense_lvl), .edge_evt(edge_evt), .nmi_pend(nmi_pend)
);

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
  localparam int N = 6;

  logic        clk = 0, rst_n = 0, accept_en = 0, nmi_pin = 1;
  logic        reg_we = 0, ack_mask = 0, ack_fast = 0;
  logic [N-1:0] irq_pin = '1;
  logic [3:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [2:0]  cpu_ipl = 0;
  wire  [15:0] reg_rdata, ack_info;
  wire         irq_req;
  wire  [2:0]  irq_num, irq_level;

  ext_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .accept_en(accept_en), .irq_pin(irq_pin),
    .nmi_pin(nmi_pin), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_ipl(cpu_ipl),
    .ack_mask(ack_mask), .ack_fast(ack_fast), .irq_req(irq_req),
    .irq_num(irq_num), .irq_level(irq_level), .ack_info(ack_info)
  );

  always #2 clk = ~clk;

  int    checks = 0, fails = 0;
  string tag = "R1";

  bit ms1[N], ms2[N], mprev[N], mreq[N], msense[N], mpol[N];
  int mprio[N];
  bit mn1, mn2, mflt, mpend;
  int mcnt, mw;

  task automatic present(output bit r, output int num, output int lvl);
    int bl = 0, bi = 0;
    for (int i = 0; i < N; i++)
      if (mreq[i] && mprio[i] > bl) begin bl = mprio[i]; bi = i; end
    r   = accept_en && (mpend || (bl > 0 && bl > int'(cpu_ipl)));
    num = !r ? 0 : (mpend ? N : bi);
    lvl = !r ? 0 : (mpend ? 7 : bl);
  endtask

  always @(posedge clk) begin
    bit r, ack, act, edg, clr, fall;
    int num, lvl, ew;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        ms1[i] = 0; ms2[i] = 0; mprev[i] = 1; mreq[i] = 0;
        msense[i] = 0; mpol[i] = 0; mprio[i] = 0;
      end
      mn1 = 1; mn2 = 1; mflt = 1; mpend = 0; mcnt = 0; mw = 2;
    end else begin
      present(r, num, lvl);
      ack = (ack_mask || ack_fast) && r;
      for (int i = 0; i < N; i++) begin
        act = mpol[i] ? ms2[i] : !ms2[i];
        edg = act && !mprev[i];
        clr = (ack && num == i) || (reg_we && reg_addr == 4 + i && !reg_wdata[5]);
        mreq[i]  = msense[i] ? (act && !clr) : (edg || (mreq[i] && !clr));
        mprev[i] = act;
        ms2[i]   = ms1[i];
        ms1[i]   = irq_pin[i];
        if (reg_we && reg_addr == 4 + i) begin
          mprio[i] = reg_wdata[2:0]; msense[i] = reg_wdata[3]; mpol[i] = reg_wdata[4];
        end
      end
      ew = (mw == 0) ? 1 : mw;
      fall = 0;
      if (mn2 != mflt) begin
        if (mcnt + 1 >= ew) begin fall = !mn2; mflt = mn2; mcnt = 0; end
        else mcnt++;
      end else mcnt = 0;
      if (fall) mpend = 1;
      else if (ack && num == N) mpend = 0;
      mn2 = mn1;
      mn1 = nmi_pin;
      if (reg_we && reg_addr == 10) mw = reg_wdata[7:0];
    end
  end

  function automatic int exp_rdata(int num, int lvl);
    int a = reg_addr;
    if (a == 0 || a == 2) return (lvl << 8) | num;
    if (a >= 4 && a < 4 + N)
      return (int'(mreq[a-4]) << 5) | (int'(mpol[a-4]) << 4) | (int'(msense[a-4]) << 3) | mprio[a-4];
    if (a == 10) return mw;
    return 0;
  endfunction

  task automatic compare();
    bit r; int num, lvl, er, ei;
    present(r, num, lvl);
    er = exp_rdata(num, lvl);
    ei = (lvl << 8) | num;
    checks++;
    if (irq_req !== r || int'(irq_num) != num || int'(irq_level) != lvl ||
        int'(ack_info) != ei || int'(reg_rdata) != er) begin
      fails++;
      $display("FAIL %s: req/num/lvl/info/rdata got %0b/%0d/%0d/%h/%h exp %0b/%0d/%0d/%h/%h",
               tag, irq_req, irq_num, irq_level, ack_info, reg_rdata, r, num, lvl, ei, er);
    end
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (rst_n) compare();
    end
  endtask

  task automatic chk(string t, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h exp %0h", t, got, exp);
    end
  endtask

  task automatic wr(int a, int d);
    reg_we = 1; reg_addr = 4'(a); reg_wdata = 16'(d);
    tick();
    reg_we = 0;
  endtask

  task automatic ack(bit fast);
    if (fast) ack_fast = 1; else ack_mask = 1;
    tick();
    ack_fast = 0; ack_mask = 0;
  endtask

  initial begin
    #600000;
    checks++; fails++;
    $display("FAIL watchdog: got hung exp finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    chk("R1 req in reset", irq_req, 0);
    rst_n = 1;
    reg_addr = 10; tick();
    chk("R1 nmi width", reg_rdata, 2);
    reg_addr = 4; tick();
    chk("R1 ctrl0", reg_rdata, 0);
    chk("R1 no request", irq_req, 0);

    tag = "R2";
    accept_en = 1;
    wr(4, 'h03);
    irq_pin[0] = 0;
    tick(2);
    chk("R2 not yet", irq_req, 0);
    tick();
    chk("R2 third edge", irq_req, 1);
    chk("R2 num", irq_num, 0);
    chk("R2 level", irq_level, 3);

    tag = "R7";
    reg_addr = 0; tick(3);
    chk("R7 sw read keeps", irq_req, 1);
    chk("R12 info word", reg_rdata, 'h0300);
    reg_addr = 2; tick();
    chk("R12 fast view", reg_rdata, 'h0300);
    ack(0);
    chk("R7 ack clears", irq_req, 0);

    tag = "R5";
    wr(5, 'h05); wr(6, 'h05); wr(7, 'h00);
    irq_pin[3:1] = 3'b000;
    tick(4);
    chk("R5 tie lower", irq_num, 1);
    chk("R5 level", irq_level, 5);
    ack(0);
    chk("R5 next", irq_num, 2);
    ack(1);
    chk("R5 level0 hidden", irq_req, 0);
    reg_addr = 7; tick();
    chk("R5 req held", reg_rdata, 'h20);

    tag = "R8";
    wr(7, 'h20); tick();
    chk("R8 write1 ignored", reg_rdata, 'h20);
    wr(7, 'h00); tick();
    chk("R8 write0 clears", reg_rdata, 'h00);

    tag = "R6";
    wr(8, 'h02); cpu_ipl = 2;
    irq_pin[4] = 0;
    tick(4);
    chk("R6 not above ipl", irq_req, 0);
    cpu_ipl = 1; tick();
    chk("R6 above ipl", irq_num, 4);
    chk("R6 req", irq_req, 1);
    accept_en = 0; tick();
    chk("R6 gated", irq_req, 0);
    accept_en = 1; cpu_ipl = 0; tick();
    ack(0);

    tag = "R3";
    wr(9, 'h14);
    tick();
    chk("R3 polarity raise num", irq_num, 5);
    chk("R3 polarity raise lvl", irq_level, 4);
    ack(1);
    chk("R3 cleared", irq_req, 0);

    tag = "R4";
    wr(4, 'h0B);
    tick();
    chk("R4 level req", irq_num, 0);
    chk("R4 level req on", irq_req, 1);
    ack(0);
    chk("R4 ack drop", irq_req, 0);
    tick();
    chk("R4 reassert", irq_req, 1);
    irq_pin[0] = 1;
    tick(4);
    chk("R4 follows level", irq_req, 0);

    tag = "R11";
    irq_pin[1] = 1; tick(4);
    irq_pin[1] = 0; tick(2);
    wr(5, 'h05);
    chk("R11 set wins", irq_num, 1);
    chk("R11 set wins req", irq_req, 1);
    ack(0);

    tag = "R9";
    wr(10, 4); cpu_ipl = 7;
    nmi_pin = 0; tick(3); nmi_pin = 1; tick(8);
    chk("R9 short pulse", irq_req, 0);
    tag = "R10";
    nmi_pin = 0; tick(5); nmi_pin = 1; tick(4);
    chk("R10 nmi presented", irq_req, 1);
    chk("R10 nmi num", irq_num, 6);
    chk("R10 nmi level", irq_level, 7);
    chk("R12 nmi info", ack_info, 'h0706);
    ack(1);
    chk("R10 nmi ack", irq_req, 0);
    tag = "R9";
    wr(10, 0);
    nmi_pin = 0; tick(); nmi_pin = 1; tick(5);
    chk("R9 width0 accepts", irq_num, 6);
    ack(0);
    cpu_ipl = 0;

    tag = "R12";
    for (int c = 0; c < 3000; c++) begin
      irq_pin ^= 6'(($urandom % 8 == 0) ? (1 << ($urandom % N)) : 0);
      if ($urandom % 16 == 0) nmi_pin = ~nmi_pin;
      cpu_ipl = 3'($urandom);
      accept_en = ($urandom % 8) != 0;
      ack_mask = ($urandom % 5) == 0;
      ack_fast = ($urandom % 11) == 0;
      reg_we = ($urandom % 8) == 0;
      if (reg_we) begin
        reg_addr = 4'(4 + $urandom % 7);
        reg_wdata = (reg_addr == 10) ? 16'($urandom % 4) : 16'($urandom % 64);
      end else begin
        reg_addr = 4'($urandom);
      end
      tick();
    end
    reg_we = 0; ack_mask = 0; ack_fast = 0;
    tick();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule